// File: doc/BRIEF.md
# Fractional Oversampling Baud Timing Generator

This block produces the bit-timing strobes that a UART transmitter and receiver run from. A clock prescaler divides the system clock by a programmable divisor to make an oversample tick. A per-bit counter groups those ticks into bit periods and flags the tick on which received data should be sampled and the tick that closes each bit. The serialiser around it supplies a frame-start pulse and the index of the bit currently in flight.

Two timing modes exist. The legacy mode always groups sixteen ticks into a bit and samples in its middle. The fast mode, meant for rates above one sixteenth of the clock, takes a programmable tick count per bit and a programmable sample tick. It also takes a 10-bit stretch mask that lengthens chosen bits of the frame by one tick. Spreading the set bits of that mask over the frame gives a baud rate correction in tenths of a tick. Configuration writes go to shadow registers and are copied into the working set only when a frame starts, so a frame in progress always keeps one timing.

Top module: `ubg_baud_gen`

## Requirements
- R1: After reset no tick, sample or bit-end strobe is produced until the first frame-start pulse. The working configuration after reset is mode 0, divisor 1, tick count 0, sample tick 0xFF and stretch mask 0.
- R2: A frame-start pulse restarts the prescaler and the tick-in-bit counter. With an effective divisor D, tick pulses in the D-th cycle after the frame-start cycle and then once every D cycles. A new frame-start pulse aborts any frame in progress.
- R3: A divisor value of 0 behaves exactly like a divisor of 1.
- R4: A mode field value other than 3 (0, 1 or 2) selects legacy timing: every bit lasts 16 ticks and the sample strobe falls on tick index 7 of the bit. The tick count, sample tick and stretch mask registers then have no effect.
- R5: Mode field value 3 selects fast timing: an unstretched bit lasts (tick count + 1) ticks.
- R6: In fast timing the sample strobe falls on the tick whose zero-based index within the current bit equals the sample tick register. If that index is not below the bit's length in ticks, no sample strobe occurs in that bit.
- R7: In fast timing, when mask bit k is set and the bit index input equals k (0 to 9), bit k lasts one tick longer. Mask bits 7:0 come from the low stretch register and mask bits 9:8 from bits 1:0 of the high stretch register. Bit index values 10 to 15 are never stretched.
- R8: The bit-end strobe coincides with the last tick of every bit, and the next tick begins a new bit at tick index 0.
- R9: A register write only reaches the shadow set. The working set takes the shadow values at a frame-start pulse. A write made in the same cycle as a frame-start pulse therefore applies from the following frame start.
- R10: Register addresses are: 0 mode (data bits 1:0), 1 divisor (bits 15:0), 2 tick count (bits 7:0), 3 sample tick (bits 7:0), 4 stretch mask low (bits 7:0), 5 stretch mask high (bits 1:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| frame_start | input | 1 | One-cycle pulse starting a frame and loading the shadow configuration |
| bit_idx | input | 4 | Index of the bit in flight (0 = start bit) |
| tick | output | 1 | Oversample tick strobe |
| sample | output | 1 | Receive sample strobe |
| bit_end | output | 1 | Last tick of the current bit |

## Verification
The two functions that can share a cycle are the loading of the working configuration at a frame-start pulse and a register write to the shadow set. The bench provokes this collision by writing the mode register in the very cycle it raises frame start, and also by writing the divisor in the middle of a running frame. It judges the result by timing every strobe of that frame against the old configuration and every strobe of the next frame against the new one. The rest of the bench sweeps divisors, tick counts, sample ticks past the bit end, and all eleven tenth-step stretch masks, computing each strobe's expected cycle arithmetically.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

    localparam int MODE_W   = 2;
    localparam int DIV_W    = 16;
    localparam int OSR_W    = 8;
    localparam int FRAC_W   = 10;
    localparam int BIDX_W   = 4;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 16;
    localparam int TIDX_W   = OSR_W + 1;
    localparam int LEGACY_TICKS = 16;
    localparam int LEGACY_SAMPLE = LEGACY_TICKS / 2 - 1;
    localparam int MASK_SPAN = 1 << BIDX_W;

    localparam logic [MODE_W-1:0] MODE_FAST = 2'd3;

    localparam logic [ADDR_W-1:0] RA_MODE    = 3'd0;
    localparam logic [ADDR_W-1:0] RA_DIV     = 3'd1;
    localparam logic [ADDR_W-1:0] RA_OSR     = 3'd2;
    localparam logic [ADDR_W-1:0] RA_SPT     = 3'd3;
    localparam logic [ADDR_W-1:0] RA_FRAC_LO = 3'd4;
    localparam logic [ADDR_W-1:0] RA_FRAC_HI = 3'd5;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [DIV_W-1:0]  div;
        logic [OSR_W-1:0]  osr;
        logic [OSR_W-1:0]  spt;
        logic [FRAC_W-1:0] frac;
    } timing_cfg_t;

    localparam timing_cfg_t CFG_RESET = '{
        mode: '0,
        div:  16'd1,
        osr:  '0,
        spt:  '1,
        frac: '0
    };

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

    function automatic logic is_fast(input logic [MODE_W-1:0] m);
        return m == MODE_FAST;
    endfunction

endpackage

// File: rtl/ubg_cfg.sv
module ubg_cfg
    import ubg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_start,
    output timing_cfg_t       active
);

    timing_cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= CFG_RESET;
        end else if (wr_en) begin
            case (wr_addr)
                RA_MODE:    shadow.mode            <= wr_data[MODE_W-1:0];
                RA_DIV:     shadow.div             <= wr_data[DIV_W-1:0];
                RA_OSR:     shadow.osr             <= wr_data[OSR_W-1:0];
                RA_SPT:     shadow.spt             <= wr_data[OSR_W-1:0];
                RA_FRAC_LO: shadow.frac[7:0]       <= wr_data[7:0];
                RA_FRAC_HI: shadow.frac[FRAC_W-1:8] <= wr_data[FRAC_W-9:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            active <= CFG_RESET;
        else if (frame_start)
            active <= shadow;
    end

    // R9: working set only moves on a frame start
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(active));

endmodule

// File: rtl/ubg_prescale.sv
module ubg_prescale
    import ubg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             running
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;
    logic             wrap;

    assign limit = eff_div(div);
    assign wrap  = cnt >= (limit - DIV_W'(1));
    assign tick  = running && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (frame_start) begin
            cnt     <= '0;
            running <= 1'b1;
        end else if (running) begin
            cnt <= wrap ? '0 : cnt + DIV_W'(1);
        end
    end

    // R2: frame start restarts the prescaler
    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (cnt == '0) && running);

    // R2: ticks are spaced by the divisor when it exceeds one
    a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
        tick && (limit != DIV_W'(1)) && !frame_start |=> !tick);

    // R3: a zero divisor ticks on every running cycle
    a_r3_zero_div: assert property (@(posedge clk) disable iff (rst)
        running && (div == '0) |-> tick);

endmodule

// File: rtl/ubg_bit_timer.sv
module ubg_bit_timer
    import ubg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              tick,
    input  timing_cfg_t       cfg,
    input  logic [BIDX_W-1:0] bit_idx,
    output logic              sample,
    output logic              bit_end
);

    logic [TIDX_W-1:0]    tidx;
    logic [TIDX_W-1:0]    last_idx;
    logic [TIDX_W-1:0]    spt_idx;
    logic [MASK_SPAN-1:0] mask_ext;
    logic                 fast;
    logic                 stretch;
    logic                 at_last;

    assign fast     = is_fast(cfg.mode);
    assign mask_ext = {{(MASK_SPAN-FRAC_W){1'b0}}, cfg.frac};
    assign stretch  = fast && mask_ext[bit_idx];

    always_comb begin
        if (fast) begin
            last_idx = {1'b0, cfg.osr} + {{(TIDX_W-1){1'b0}}, stretch};
            spt_idx  = {1'b0, cfg.spt};
        end else begin
            last_idx = TIDX_W'(LEGACY_TICKS - 1);
            spt_idx  = TIDX_W'(LEGACY_SAMPLE);
        end
    end

    assign at_last = tidx >= last_idx;
    assign bit_end = tick && at_last;
    assign sample  = tick && (tidx == spt_idx);

    always_ff @(posedge clk) begin
        if (rst || frame_start)
            tidx <= '0;
        else if (tick)
            tidx <= at_last ? '0 : tidx + TIDX_W'(1);
    end

    // R8: a bit end is followed by tick index 0
    a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
        bit_end |=> (tidx == '0));

    // R4: legacy bits never count past sixteen ticks
    a_r4_legacy_range: assert property (@(posedge clk) disable iff (rst)
        !fast |-> (tidx < TIDX_W'(LEGACY_TICKS)));

endmodule

// File: rtl/ubg_baud_gen.sv
module ubg_baud_gen
    import ubg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_start,
    input  logic [BIDX_W-1:0] bit_idx,
    output logic              tick,
    output logic              sample,
    output logic              bit_end
);

    timing_cfg_t active_cfg;
    logic        running;

    ubg_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .active      (active_cfg)
    );

    ubg_prescale u_pre (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .div         (active_cfg.div),
        .tick        (tick),
        .running     (running)
    );

    ubg_bit_timer u_bit (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .tick        (tick),
        .cfg         (active_cfg),
        .bit_idx     (bit_idx),
        .sample      (sample),
        .bit_end     (bit_end)
    );

    // R1: nothing is strobed before the first frame start
    a_r1_quiet: assert property (@(posedge clk) disable iff (rst)
        !running |-> !(sample || bit_end));

endmodule

// File: tb/ubg_baud_gen_test.sv
`timescale 1ns/1ps
module ubg_baud_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        frame_start = 1'b0;
    logic [3:0]  bit_idx = '0;
    logic        tick, sample, bit_end;

    int checks = 0;
    int failures = 0;

    int sh_mode = 0, sh_div = 1, sh_osr = 0, sh_spt = 255, sh_frac = 0;
    int ac_mode = 0, ac_div = 1, ac_osr = 0, ac_spt = 255, ac_frac = 0;

    always #10 clk = ~clk;

    ubg_baud_gen uut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .frame_start (frame_start), .bit_idx (bit_idx),
        .tick (tick), .sample (sample), .bit_end (bit_end)
    );

    function automatic void apply_sh(input int a, input int d);
        case (a)
            0: sh_mode = d & 3;
            1: sh_div  = d & 16'hFFFF;
            2: sh_osr  = d & 8'hFF;
            3: sh_spt  = d & 8'hFF;
            4: sh_frac = (sh_frac & 32'h300) | (d & 8'hFF);
            5: sh_frac = (sh_frac & 32'h0FF) | ((d & 3) << 8);
            default: ;
        endcase
    endfunction

    task automatic check3(input string tag, input int n, input logic [2:0] exp_v);
        checks++;
        if ({tick, sample, bit_end} !== exp_v) begin
            failures++;
            $display("FAIL %s cycle=%0d tick/sample/end actual=%b expected=%b",
                     tag, n, {tick, sample, bit_end}, exp_v);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        apply_sh(a, d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // cut: cycles to check (0 = whole frame); wcyc: mid-frame write cycle (0 = none);
    // scw: write in the frame-start cycle itself
    task automatic run_frame(input string tag, input int cut, input int wcyc,
                             input int wa, input int wd,
                             input bit scw, input int sca, input int scd);
        int d, total, spe, ncyc;
        bit fast;
        int len[10];
        @(posedge clk); #1;
        frame_start = 1'b1;
        bit_idx = '0;
        ac_mode = sh_mode; ac_div = sh_div; ac_osr = sh_osr;
        ac_spt = sh_spt; ac_frac = sh_frac;
        if (scw) begin
            wr_en = 1'b1; wr_addr = 3'(sca); wr_data = 16'(scd);
            apply_sh(sca, scd);
        end
        d = (ac_div == 0) ? 1 : ac_div;
        fast = (ac_mode == 3);
        spe = fast ? ac_spt : 7;
        total = 0;
        for (int k = 0; k < 10; k++) begin
            len[k] = fast ? (ac_osr + 1 + ((ac_frac >> k) & 1)) : 16;
            total += len[k];
        end
        ncyc = (cut > 0) ? cut : d * total;
        @(posedge clk); #1;
        frame_start = 1'b0;
        wr_en = 1'b0;
        for (int n = 1; n <= ncyc; n++) begin
            int t, s, k, p;
            bit tk;
            t = (n - 1) / d;
            s = 0; k = 0;
            while (k < 9 && t >= s + len[k]) begin
                s += len[k];
                k++;
            end
            bit_idx = 4'(k);
            if (n == wcyc) begin
                wr_en = 1'b1; wr_addr = 3'(wa); wr_data = 16'(wd);
                apply_sh(wa, wd);
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            tk = (n % d) == 0;
            p = t - s;
            check3(tag, n, {tk, tk && (p == spe), tk && (p == len[k] - 1)});
            @(posedge clk); #1;
        end
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired checks=%0d", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int fr[11];
        int spts[4];
        fr = '{12'h000, 12'h001, 12'h005, 12'h015, 12'h055, 12'h057,
               12'h157, 12'h177, 12'h17F, 12'h1FF, 12'h3FF};

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: quiet until the first frame start
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check3("R1", i, 3'b000);
        end

        // R1 reset configuration runs legacy timing with divisor 1
        run_frame("R1/R4", 0, 0, 0, 0, 1'b0, 0, 0);

        // R4 and R10: legacy sweep with the fast-only registers loaded with noise
        wr(2, 5); wr(3, 2); wr(4, 8'hFF); wr(5, 3);
        for (int m = 0; m < 3; m++) begin
            for (int di = 0; di < 4; di++) begin
                int dv;
                dv = (di == 3) ? 5 : di;
                wr(0, m); wr(1, dv);
                run_frame("R4/R10/R2", 0, 0, 0, 0, 1'b0, 0, 0);
            end
        end

        // R5/R6/R7/R8 fast sweep, R3 with divisor 0
        wr(0, 3);
        for (int di = 0; di < 3; di++) begin
            wr(1, di);
            for (int oi = 0; oi < 2; oi++) begin
                int osr;
                osr = (oi == 0) ? 3 : 7;
                wr(2, osr);
                spts = '{0, osr >> 1, osr + 1, 255};
                for (int si = 0; si < 4; si++) begin
                    wr(3, spts[si]);
                    for (int fi = 0; fi < 11; fi++) begin
                        wr(4, fr[fi] & 8'hFF);
                        wr(5, fr[fi] >> 8);
                        run_frame(di == 0 ? "R3/R5/R6/R7/R8" : "R5/R6/R7/R8",
                                  0, 0, 0, 0, 1'b0, 0, 0);
                    end
                end
            end
        end

        // R2: abort a frame part way and restart
        wr(1, 2); wr(2, 4); wr(3, 1); wr(4, 8'h21); wr(5, 2);
        run_frame("R2", 37, 0, 0, 0, 1'b0, 0, 0);
        run_frame("R2", 0, 0, 0, 0, 1'b0, 0, 0);

        // R9: mid-frame divisor write leaves the running frame alone
        wr(1, 1); wr(4, 0); wr(5, 0);
        run_frame("R9", 0, 10, 1, 3, 1'b0, 0, 0);
        run_frame("R9", 0, 0, 0, 0, 1'b0, 0, 0);
        // R9: write in the frame-start cycle applies one frame later
        run_frame("R9", 0, 0, 0, 0, 1'b1, 0, 0);
        run_frame("R9", 0, 0, 0, 0, 1'b0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule